// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause-22 management frames on a two-wire MDC/MDIO link for a host that sees it only as three 32-bit registers.

Software sets an enable flag and a clock divider in the control word. It then writes one access word that carries:
- a go flag;
- a direction flag;
- a 5-bit PHY address;
- a 5-bit register address;
- 16 data bits.

The block shifts out the frame and clocks MDC only while the frame is in flight. It lets go of the data line while a PHY answers a read. When the frame is over it drops the busy flag and, for a read, leaves the PHY's data in the low half of the same word. A presence bitmap records every PHY address that answered a read during the turnaround. That lets a scan of all 32 addresses find the attached devices.

The serial side is the usual tristate trio: an output bit, an output-enable and an input bit. The pad and pull-up sit outside the block.

The frame engine is one state machine:
- IDLE: waits for a start.
- PREAMBLE: sends the run of ones.
- START: sends the start pattern.
- OPCODE: sends the direction code.
- ADDRESS: sends the PHY address, then the register address.
- TURN: turnaround.
- DATA: the 16 data bits.

Each state moves to the next in that order when its last bit period ends, and DATA returns to IDLE. IDLE leaves only on an accepted start.

Top module: `mdio_master`

## Requirements
- R1: After reset:
  - the control word (select 0) reads 0x8000_0000;
  - the access word (select 1) and the presence map (select 2) read 0;
  - MDC and the output-enable are low.
- R2: Writing the access word with bit 31 set while control bit 30 (enable) is 1 and no frame runs starts a frame:
  - from the next cycle, access bit 31 reads 1 and control bit 31 (idle) reads 0.
  - The access word layout is: bit 30 = 1 for a write, bits 25:21 = register address, bits 20:16 = PHY address, bits 15:0 = data. Bits 29:26 read 0.
- R3: MDC timing, with D the control divider in bits 7:0 (a value of 0 acts as 1):
  - each bit period lasts D+1 clocks;
  - MDC is low for the first floor(D/2)+1 clocks of each period and high for the rest;
  - MDC is low whenever no frame runs.
- R4: Every frame begins with the output-enable high for these bits, in order:
  - 32 ones;
  - 0, 1;
  - the opcode: 1, 0 for a read or 0, 1 for a write;
  - the PHY address, then the register address, each most significant bit first.
- R5: A write frame drives the turnaround as 1, 0 and then the 16 data bits, most significant bit first, with the output-enable high throughout.
- R6: A read frame releases the output-enable for its last 18 bit periods. It samples the input at each MDC rise of the 16 data periods, most significant bit first. When the frame ends, the sampled word appears in access bits 15:0.
- R7: Busy (access bit 31) clears exactly 64·(D+1) clocks after the frame starts. The write flag and both addresses read back unchanged; a write frame also keeps its data.
- R8: A read frame that finds the input low at the MDC rise of the second turnaround bit sets the presence bit indexed by its PHY address. Bits are never cleared except by reset. A high input there, or a write frame, sets nothing.
- R9: A write to the access word while a frame runs is ignored: the word and the frame are unchanged.
- R10: With enable clear, an access write stores the fields but leaves bit 31 at 0, and no frame or MDC activity follows.
- R11: Writes to the presence map and to the idle bit have no effect, and select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 access, 2 presence map |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output-enable |
| mdio_i | input | 1 | Serial data in |

## Verification
The assertions assume the following about the block's inputs:
- software changes the divider only while no frame runs;
- it waits for busy to drop before issuing another access, since a write during a frame is only checked for being dropped;
- the PHY changes the input only while MDC is low.

The bench writes the divider only between frames. It drives the input from its reference model at the falling system clock edge, holding each bit for a whole bit period. It issues its one deliberate mid-frame access solely to test that the access is ignored.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int SEL_CTRL  = 0;
    localparam int SEL_ACC   = 1;
    localparam int SEL_ALIVE = 2;

    localparam int GO_BIT    = 31;
    localparam int WR_BIT    = 30;
    localparam int EN_BIT    = 30;
    localparam int REG_LSB   = 21;
    localparam int PHY_LSB   = 16;
    localparam int AW        = 5;
    localparam int DW        = 16;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] phy;
        logic [AW-1:0] regad;
        logic [DW-1:0] data;
    } mdio_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRE, ST_START, ST_OP, ST_ADDR, ST_TURN, ST_DATA
    } mdio_state_e;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             bit_end
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] half;

    assign div_eff = (div == '0) ? DIV_W'(1) : div;
    assign half    = div_eff >> 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == div_eff) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc     = run && (cnt_q > half);
    assign rise    = run && (cnt_q == half);
    assign bit_end = run && (cnt_q == div_eff);
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  mdio_cmd_t     cmd,
    input  logic          rise,
    input  logic          bit_end,
    input  logic          mdio_i,
    output logic          busy,
    output logic          done,
    output logic          mdio_o,
    output logic          mdio_oe,
    output logic [DW-1:0] rx_data,
    output logic          alive_hit,
    output logic [AW-1:0] alive_phy
);
    localparam int MAXLEN = (PRE_LEN > DW) ? PRE_LEN : DW;
    localparam int CNT_W  = $clog2(MAXLEN);

    mdio_state_e     state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             wr_q;
    logic [AW-1:0]    phy_q;
    logic [2*AW-1:0]  hdr_q;
    logic [DW-1:0]    tx_q;
    logic [DW-1:0]    rx_q;

    function automatic logic [CNT_W-1:0] last_idx(mdio_state_e s);
        unique case (s)
            ST_PRE:  return CNT_W'(PRE_LEN - 1);
            ST_ADDR: return CNT_W'(2*AW - 1);
            ST_DATA: return CNT_W'(DW - 1);
            default: return CNT_W'(1);
        endcase
    endfunction

    function automatic mdio_state_e succ(mdio_state_e s);
        unique case (s)
            ST_PRE:   return ST_START;
            ST_START: return ST_OP;
            ST_OP:    return ST_ADDR;
            ST_ADDR:  return ST_TURN;
            ST_TURN:  return ST_DATA;
            default:  return ST_IDLE;
        endcase
    endfunction

    // next-state logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (state_q == ST_IDLE) begin
            if (start) begin
                state_n = ST_PRE;
                cnt_n   = '0;
            end
        end else if (bit_end) begin
            if (cnt_q == last_idx(state_q)) begin
                state_n = succ(state_q);
                cnt_n   = '0;
            end else begin
                cnt_n = cnt_q + 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // frame data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= 1'b0;
            phy_q <= '0;
            hdr_q <= '0;
            tx_q  <= '0;
            rx_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                wr_q  <= cmd.wr;
                phy_q <= cmd.phy;
                hdr_q <= {cmd.phy, cmd.regad};
                tx_q  <= cmd.data;
            end
            if (bit_end && state_q == ST_ADDR) hdr_q <= {hdr_q[2*AW-2:0], 1'b0};
            if (bit_end && state_q == ST_DATA) tx_q  <= {tx_q[DW-2:0], 1'b0};
            if (rise && state_q == ST_DATA && !wr_q) rx_q <= {rx_q[DW-2:0], mdio_i};
        end
    end

    // outputs
    always_comb begin
        mdio_o  = 1'b1;
        mdio_oe = 1'b1;
        unique case (state_q)
            ST_IDLE:  mdio_oe = 1'b0;
            ST_PRE:   mdio_o  = 1'b1;
            ST_START: mdio_o  = (cnt_q != '0);
            ST_OP:    mdio_o  = (cnt_q == '0) ? !wr_q : wr_q;
            ST_ADDR:  mdio_o  = hdr_q[2*AW-1];
            ST_TURN: begin
                mdio_o  = (cnt_q == '0);
                mdio_oe = wr_q;
            end
            ST_DATA: begin
                mdio_o  = wr_q ? tx_q[DW-1] : 1'b1;
                mdio_oe = wr_q;
            end
            default: mdio_oe = 1'b0;
        endcase
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = bit_end && state_q == ST_DATA && cnt_q == CNT_W'(DW - 1);
    assign rx_data   = rx_q;
    assign alive_hit = rise && state_q == ST_TURN && cnt_q == CNT_W'(1) && !wr_q && !mdio_i;
    assign alive_phy = phy_q;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             busy,
    input  logic             done,
    input  logic [DW-1:0]    rx_data,
    input  logic             alive_hit,
    input  logic [AW-1:0]    alive_phy,
    output logic             start,
    output mdio_cmd_t        cmd,
    output logic [DIV_W-1:0] div
);
    logic             en_q;
    logic [DIV_W-1:0] div_q;
    mdio_cmd_t        acc_q;
    logic [31:0]      alive_q;
    logic             acc_take;
    logic             unused_bits;

    assign unused_bits = ^bus_wdata[29:26];

    assign cmd = '{wr:    bus_wdata[WR_BIT],
                   phy:   bus_wdata[PHY_LSB +: AW],
                   regad: bus_wdata[REG_LSB +: AW],
                   data:  bus_wdata[DW-1:0]};

    assign acc_take = bus_wr && bus_addr == 2'(SEL_ACC) && !busy;
    assign start    = acc_take && bus_wdata[GO_BIT] && en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            div_q   <= '0;
            acc_q   <= '0;
            alive_q <= '0;
        end else begin
            if (bus_wr && bus_addr == 2'(SEL_CTRL)) begin
                en_q  <= bus_wdata[EN_BIT];
                div_q <= bus_wdata[DIV_W-1:0];
            end
            if (acc_take) acc_q <= cmd;
            if (done && !acc_q.wr) acc_q.data <= rx_data;
            if (alive_hit) alive_q[alive_phy] <= 1'b1;
        end
    end

    always_comb begin
        unique case (bus_addr)
            2'(SEL_CTRL):  bus_rdata = {!busy, en_q, {(30-DIV_W){1'b0}}, div_q};
            2'(SEL_ACC):   bus_rdata = {busy, acc_q.wr, 4'b0, acc_q.regad, acc_q.phy, acc_q.data};
            2'(SEL_ALIVE): bus_rdata = alive_q;
            default:       bus_rdata = '0;
        endcase
    end

    assign div = div_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic             busy, done, start, rise, bit_end, alive_hit;
    logic [DW-1:0]    rx_data;
    logic [AW-1:0]    alive_phy;
    logic [DIV_W-1:0] div;
    mdio_cmd_t        cmd;

    mdio_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done(done),
        .rx_data(rx_data), .alive_hit(alive_hit), .alive_phy(alive_phy),
        .start(start), .cmd(cmd), .div(div)
    );

    mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div),
        .mdc(mdc), .rise(rise), .bit_end(bit_end)
    );

    mdio_frame_fsm #(.PRE_LEN(PRE_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .rise(rise),
        .bit_end(bit_end), .mdio_i(mdio_i), .busy(busy), .done(done),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rx_data(rx_data),
        .alive_hit(alive_hit), .alive_phy(alive_phy)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic       busy,
    input logic       start,
    input logic       done,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe
);
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy);
    // R2
    busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
    // R3
    idle_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdc);
    // R4
    mdio_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mdc && $past(mdc)) |-> $stable(mdio_o));
    // R5
    oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) mdio_oe |-> busy);
    // R7
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
    // R9
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == 2'(SEL_ACC)) |-> !start);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .busy(busy), .start(start), .done(done), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n, bus_wr, mdio_i;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        mdc, mdio_o, mdio_oe;

    always #4 clk = ~clk;

    mdio_master dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    bit m_active = 0;
    int m_cyc = 0, m_div = 1;
    bit exp_o[64], exp_oe[64], rsp[64];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model, compared every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_active) begin
                int b, ph;
                b  = m_cyc / (m_div + 1);
                ph = m_cyc % (m_div + 1);
                chk("R3 mdc", {31'b0, mdc}, {31'b0, ph > m_div / 2});
                chk("R4 R5 R6 oe", {31'b0, mdio_oe}, {31'b0, exp_oe[b]});
                if (exp_oe[b]) chk("R4 R5 data out", {31'b0, mdio_o}, {31'b0, exp_o[b]});
                mdio_i = rsp[b];
                m_cyc++;
                if (m_cyc == 64 * (m_div + 1)) m_active = 0;
            end else begin
                chk("R3 R10 idle mdc", {31'b0, mdc}, 32'd0);
                chk("R10 idle oe", {31'b0, mdio_oe}, 32'd0);
                mdio_i = 1'b1;
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_ctrl(input bit en, input logic [7:0] dv);
        bus_write(2'd0, {1'b0, en, 22'b0, dv});
        m_div = (dv == 0) ? 1 : dv;
    endtask

    task automatic go(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                      input logic [15:0] d, input bit ta, input logic [15:0] rd, input bit run);
        for (int i = 0; i < 64; i++) begin exp_oe[i] = 1; exp_o[i] = 1; rsp[i] = 1; end
        exp_o[32] = 0; exp_o[33] = 1;
        exp_o[34] = !wr; exp_o[35] = wr;
        for (int i = 0; i < 5; i++) begin
            exp_o[36 + i] = phy[4 - i];
            exp_o[41 + i] = rg[4 - i];
        end
        if (wr) begin
            exp_o[46] = 1; exp_o[47] = 0;
            for (int i = 0; i < 16; i++) exp_o[48 + i] = d[15 - i];
        end else begin
            for (int i = 46; i < 64; i++) exp_oe[i] = 0;
            rsp[47] = ta;
            for (int i = 0; i < 16; i++) rsp[48 + i] = rd[15 - i];
        end
        bus_write(2'd1, {1'b1, wr, 4'b0, rg, phy, d});
        if (run) begin m_active = 1; m_cyc = 0; end
    endtask

    task automatic wait_idle();
        while (m_active) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int t0;
        rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; mdio_i = 1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        bus_read(2'd0, v); chk("R1 ctrl", v, 32'h8000_0000);
        bus_read(2'd1, v); chk("R1 access", v, 32'h0);
        bus_read(2'd2, v); chk("R1 alive", v, 32'h0);

        set_ctrl(1, 8'd1);
        bus_read(2'd0, v); chk("R2 ctrl readback", v, 32'hC000_0001);

        // write frame, D=1
        t0 = 0;
        go(1, 5'd5, 5'h12, 16'hA5C3, 0, 0, 1);
        bus_read(2'd1, v); chk("R2 busy", v, {1'b1, 1'b1, 4'b0, 5'h12, 5'd5, 16'hA5C3});
        bus_read(2'd0, v); chk("R2 idle low", v, 32'h4000_0001);
        bus_write(2'd1, {1'b1, 1'b0, 4'b0, 5'd3, 5'd9, 16'h0}); // R9
        bus_read(2'd1, v); chk("R9 ignored", v, {1'b1, 1'b1, 4'b0, 5'h12, 5'd5, 16'hA5C3});
        while (m_active) begin @(negedge clk); t0++; end
        bus_read(2'd1, v); chk("R7 done write", v, {1'b0, 1'b1, 4'b0, 5'h12, 5'd5, 16'hA5C3});
        bus_read(2'd0, v); chk("R7 idle back", v, 32'hC000_0001);

        // read with response, D=4
        set_ctrl(1, 8'd4);
        go(0, 5'd3, 5'd1, 16'h0, 0, 16'h1234, 1);
        wait_idle();
        bus_read(2'd1, v); chk("R6 read data", v, {2'b0, 4'b0, 5'd1, 5'd3, 16'h1234});
        bus_read(2'd2, v); chk("R8 alive set", v, 32'h0000_0008);

        // read with no responder
        go(0, 5'd7, 5'd2, 16'h0, 1, 16'hFFFF, 1);
        wait_idle();
        bus_read(2'd1, v); chk("R6 no responder", v, {2'b0, 4'b0, 5'd2, 5'd7, 16'hFFFF});
        bus_read(2'd2, v); chk("R8 high not set", v, 32'h0000_0008);

        // read at D=3, data pattern
        set_ctrl(1, 8'd3);
        go(0, 5'd0, 5'd31, 16'h0, 0, 16'h8E71, 1);
        wait_idle();
        bus_read(2'd1, v); chk("R6 read odd D", v, {2'b0, 4'b0, 5'd31, 5'd0, 16'h8E71});
        bus_read(2'd2, v); chk("R8 phy0 set", v, 32'h0000_0009);

        // divider 0 acts as 1, write frame
        set_ctrl(1, 8'd0);
        go(1, 5'd31, 5'd31, 16'h0001, 0, 0, 1);
        wait_idle();
        bus_read(2'd2, v); chk("R8 write sets nothing", v, 32'h0000_0009);

        // disabled
        set_ctrl(0, 8'd0);
        go(0, 5'd1, 5'd2, 16'hBEEF, 0, 0, 0);
        repeat (10) @(negedge clk);
        bus_read(2'd1, v); chk("R10 stored not run", v, {2'b0, 4'b0, 5'd2, 5'd1, 16'hBEEF});

        // read-only and unused
        bus_write(2'd2, 32'hFFFF_FFFF);
        bus_read(2'd2, v); chk("R11 alive read-only", v, 32'h0000_0009);
        bus_read(2'd3, v); chk("R11 unused select", v, 32'h0);
        bus_write(2'd0, 32'h0000_0000);
        bus_read(2'd0, v); chk("R11 idle bit", v, 32'h8000_0000);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule